// File: doc/BRIEF.md
# Four-Mode Coupling-Aware Link Inversion Encoder

This block sits at the sending side of an on-chip network link. It takes one body flit of W-1 payload bits at a time and sends a W-bit link word: the payload lines, possibly inverted by one of three masks, plus one flag line on top. Before it registers the word, it compares the candidate payload with the link word it sent last. Between neighbouring wires it weighs the transitions that cost coupling energy. A pair where exactly one line switches costs 1. A pair where the two lines switch in opposite directions costs 2. All other pairs cost nothing.

For every pair of neighbouring payload lines, a first stage of detectors marks four conditions. The first is that inverting the odd lines would lower that pair's cost. The second is that inverting the even lines would lower it. The third is that the pair is an opposite-direction pair as sent. The fourth is that both lines hold while their previous values differ, so a full inversion would turn the pair into an opposite-direction pair. Four population counters total these marks. A decision stage compares the totals and picks no inversion, odd, even or full inversion. The result is reported as a two-bit mode, and the flag line tells the receiver that some inversion was applied.

Top module: `invSelEncoder`

## Requirements
- R1: While `rstN` is low, `linkWord` and `mode` are cleared to zero at each clock edge.
- R2: A flit presented with `flitValid` high is encoded and appears on `linkWord`/`mode` after the next rising clock edge. With `flitValid` low, both outputs hold their values whatever `payload` does.
- R3: Mode codes: 2'b00 sends the payload unchanged, 2'b10 inverts the odd payload lines (bits 1, 3, 5, …), 2'b01 inverts the even payload lines (bits 0, 2, 4, …), and 2'b11 inverts all payload lines. Bit W-1 of `linkWord` is 1 exactly when `mode` is not 2'b00, and `linkWord[W-2:0]` XOR the mode's mask equals the accepted payload.
- R4: The cost of a word is computed over the M = W-2 neighbouring pairs of payload lines (i, i+1) against the payload lines of the previous `linkWord`. A pair where exactly one line toggles costs 1. A pair where one line rises and the other falls costs 2. Any other pair costs 0. The flag line is not part of the cost.
- R5: Full inversion (2'b11) is chosen when 2D > 2A − M, D > 0 and 2D > 2B − M. Here A counts pairs improved by odd inversion, B counts pairs improved by even inversion, and D is the number of opposite-direction pairs minus the number of holding pairs with unequal previous values.
- R6: Odd inversion (2'b10) is chosen when 2D < 2A − M, 2A > M and B < A.
- R7: Even inversion (2'b01) is chosen when 2B > M, B > A and 2D < 2B − M.
- R8: When none of the three conditions holds, mode 2'b00 is sent. This includes ties between the best candidates. If conditions overlap, the priority is full, then odd, then even.
- R9: The cost of the sent word is never higher than that of the unmodified payload, and it is strictly lower whenever `mode` is not 2'b00.
- R10: The reference for each decision is the previously sent, already encoded link word, not the previous raw payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| flitValid | input | 1 | Accept and encode `payload` this cycle |
| payload | input | W-1 | Body flit payload |
| linkWord | output | W | Registered link word: flag at bit W-1, encoded payload below |
| mode | output | 2 | Registered inversion mode of the current link word |

## Verification
The assertions watch every cycle for four things: that the flag agrees with the mode, that unmasking the link word returns the accepted payload, that idle cycles leave the outputs alone, and that the sent word never costs more than the raw payload, and costs strictly less when a mode is applied. Whether the chosen mode is the right one among the four can be seen only in the bench scenarios. There a separate model prices all four candidates and expects the one with a strictly lowest cost. This is the selection inequalities restated in cost form. The directed scenarios cover the tie that forces no inversion, an all-opposite-direction word that needs full inversion, and random streams in which odd and even inversion must each be chosen.

// File: rtl/invsel_pkg.sv
`timescale 1ns/1ps
package invsel_pkg;

  // strobes from decision logic to datapath
  typedef struct packed {
    logic load;
    logic invOdd;
    logic invEven;
  } strobe_t;

  // coupling weight of one neighbouring pair: prev bits y, new bits x
  function automatic logic [1:0] pairCost(input logic y0, input logic y1,
                                          input logic x0, input logic x1);
    logic s0, s1;
    s0 = y0 ^ x0;
    s1 = y1 ^ x1;
    if (s0 != s1) return 2'd1;
    if (s0 && s1 && (x0 != x1)) return 2'd2;
    return 2'd0;
  endfunction

endpackage

// File: rtl/onesCounter.sv
`timescale 1ns/1ps
module onesCounter #(
  parameter int N  = 14,
  parameter int CW = 4
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(bits[i]);
  end
endmodule

// File: rtl/invDatapath.sv
`timescale 1ns/1ps
module invDatapath
  import invsel_pkg::*;
#(
  parameter int W = 16,
  localparam int PAY = W - 1,
  localparam int M = W - 2,
  localparam int CW = $clog2(M + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [PAY-1:0] payload,
  input  strobe_t        strobe,
  output logic [CW-1:0]  tyCnt,
  output logic [CW-1:0]  teCnt,
  output logic [CW-1:0]  t2Cnt,
  output logic [CW-1:0]  t4Cnt,
  output logic [W-1:0]   linkWord,
  output logic [1:0]     mode
);

  function automatic logic [PAY-1:0] lineMask(input bit oddLines);
    logic [PAY-1:0] m;
    for (int j = 0; j < PAY; j++) m[j] = ((j % 2) == 1) == oddLines;
    return m;
  endfunction

  localparam logic [PAY-1:0] OddMask  = lineMask(1'b1);
  localparam logic [PAY-1:0] EvenMask = lineMask(1'b0);

  logic [PAY-1:0] prevPay;
  logic [M-1:0]   tyBits, teBits, t2Bits, t4Bits;
  logic [PAY-1:0] nextPay;

  assign prevPay = linkWord[PAY-1:0];

  // first stage: per-pair detectors
  for (genvar i = 0; i < M; i++) begin : g_pair
    localparam bit LoIsOdd = (i % 2) == 1;
    logic y0, y1, x0, x1;
    logic [1:0] cNone, cOdd, cEven;
    assign y0 = prevPay[i];
    assign y1 = prevPay[i+1];
    assign x0 = payload[i];
    assign x1 = payload[i+1];
    assign cNone = pairCost(y0, y1, x0, x1);
    if (LoIsOdd) begin : g_lo_odd
      assign cOdd  = pairCost(y0, y1, ~x0, x1);
      assign cEven = pairCost(y0, y1, x0, ~x1);
    end else begin : g_lo_even
      assign cOdd  = pairCost(y0, y1, x0, ~x1);
      assign cEven = pairCost(y0, y1, ~x0, x1);
    end
    assign tyBits[i] = cOdd < cNone;
    assign teBits[i] = cEven < cNone;
    assign t2Bits[i] = cNone == 2'd2;
    assign t4Bits[i] = !(x0 ^ y0) && !(x1 ^ y1) && (y0 != y1);
  end

  // second stage: population counts
  onesCounter #(.N(M), .CW(CW)) u_cntTy (.bits(tyBits), .count(tyCnt));
  onesCounter #(.N(M), .CW(CW)) u_cntTe (.bits(teBits), .count(teCnt));
  onesCounter #(.N(M), .CW(CW)) u_cntT2 (.bits(t2Bits), .count(t2Cnt));
  onesCounter #(.N(M), .CW(CW)) u_cntT4 (.bits(t4Bits), .count(t4Cnt));

  assign nextPay = payload ^ (strobe.invOdd ? OddMask : '0)
                           ^ (strobe.invEven ? EvenMask : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkWord <= '0;
      mode     <= 2'b00;
    end else if (strobe.load) begin
      linkWord <= {strobe.invOdd | strobe.invEven, nextPay};
      mode     <= {strobe.invOdd, strobe.invEven};
    end
  end

endmodule

// File: rtl/invControl.sv
`timescale 1ns/1ps
module invControl
  import invsel_pkg::*;
#(
  parameter int W = 16,
  localparam int M = W - 2,
  localparam int CW = $clog2(M + 1)
) (
  input  logic          flitValid,
  input  logic [CW-1:0] tyCnt,
  input  logic [CW-1:0] teCnt,
  input  logic [CW-1:0] t2Cnt,
  input  logic [CW-1:0] t4Cnt,
  output strobe_t       strobe
);

  int  ty, te, dd;
  logic fullC, oddC, evenC;

  always_comb begin
    ty = int'(tyCnt);
    te = int'(teCnt);
    dd = int'(t2Cnt) - int'(t4Cnt);
    fullC = (2*dd > 2*ty - M) && (dd > 0) && (2*dd > 2*te - M);
    oddC  = (2*dd < 2*ty - M) && (2*ty > M) && (te < ty);
    evenC = (2*te > M) && (te > ty) && (2*dd < 2*te - M);
  end

  always_comb begin
    strobe.load = flitValid;
    if (fullC) begin
      strobe.invOdd = 1'b1; strobe.invEven = 1'b1;
    end else if (oddC) begin
      strobe.invOdd = 1'b1; strobe.invEven = 1'b0;
    end else if (evenC) begin
      strobe.invOdd = 1'b0; strobe.invEven = 1'b1;
    end else begin
      strobe.invOdd = 1'b0; strobe.invEven = 1'b0;
    end
  end

endmodule

// File: rtl/invSelEncoder.sv
`timescale 1ns/1ps
module invSelEncoder
  import invsel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flitValid,
  input  logic [W-2:0] payload,
  output logic [W-1:0] linkWord,
  output logic [1:0]   mode
);
  localparam int CW = $clog2(W - 1);

  strobe_t       strobe;
  logic [CW-1:0] tyCnt, teCnt, t2Cnt, t4Cnt;

  invDatapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .payload(payload), .strobe(strobe),
    .tyCnt(tyCnt), .teCnt(teCnt), .t2Cnt(t2Cnt), .t4Cnt(t4Cnt),
    .linkWord(linkWord), .mode(mode)
  );

  invControl #(.W(W)) u_ctl (
    .flitValid(flitValid), .tyCnt(tyCnt), .teCnt(teCnt),
    .t2Cnt(t2Cnt), .t4Cnt(t4Cnt), .strobe(strobe)
  );
endmodule

// File: rtl/invSelEncoder_chk.sv
`timescale 1ns/1ps
module invSelEncoder_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         flitValid,
  input logic [W-2:0] payload,
  input logic [W-1:0] linkWord,
  input logic [1:0]   mode
);
  localparam int PAY = W - 1;

  function automatic logic [PAY-1:0] maskOf(input logic [1:0] m);
    logic [PAY-1:0] r;
    for (int j = 0; j < PAY; j++) r[j] = (j % 2 == 1) ? m[1] : m[0];
    return r;
  endfunction

  function automatic int costOf(input logic [PAY-1:0] y, input logic [PAY-1:0] x);
    int c;
    c = 0;
    for (int i = 0; i < PAY - 1; i++) begin
      if ((y[i] ^ x[i]) != (y[i+1] ^ x[i+1])) c += 1;
      else if ((y[i] ^ x[i]) && (x[i] != x[i+1])) c += 2;
    end
    return c;
  endfunction

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (linkWord == '0 && mode == 2'b00));

  // R2
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !flitValid |=> ($stable(linkWord) && $stable(mode)));

  // R3
  p_flag_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    linkWord[W-1] == (mode != 2'b00));

  // R3
  p_decode_r3: assert property (@(posedge clk) disable iff (!rstN)
    flitValid |=> ((linkWord[PAY-1:0] ^ maskOf(mode)) == $past(payload)));

  // R9
  p_cost_not_worse_r9: assert property (@(posedge clk) disable iff (!rstN)
    flitValid |=> (costOf($past(linkWord[PAY-1:0]), linkWord[PAY-1:0])
                   <= costOf($past(linkWord[PAY-1:0]), $past(payload))));

  // R9
  p_cost_strict_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flitValid ##1 (mode != 2'b00)) |->
      (costOf($past(linkWord[PAY-1:0]), linkWord[PAY-1:0])
       < costOf($past(linkWord[PAY-1:0]), $past(payload))));

endmodule

bind invSelEncoder invSelEncoder_chk #(.W(W)) u_chk (.*);

// File: tb/tb_invSelEncoder.sv
`timescale 1ns/1ps
module tb_invSelEncoder;
  localparam int W = 16;
  localparam int PAY = W - 1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           flitValid = 1'b0;
  logic [PAY-1:0] payload = '0;
  logic [W-1:0]   linkWord;
  logic [1:0]     mode;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expLink = '0;
  int seenMode [4];
  logic [31:0] lfsr = 32'h1234_5678;

  always #2.5 clk = ~clk;

  invSelEncoder #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .flitValid(flitValid), .payload(payload),
    .linkWord(linkWord), .mode(mode)
  );

  function automatic logic [PAY-1:0] bMask(input logic [1:0] m);
    logic [PAY-1:0] r;
    r = '0;
    for (int j = 0; j < PAY; j++) begin
      if (j % 2 == 1 && m[1]) r[j] = 1'b1;
      if (j % 2 == 0 && m[0]) r[j] = 1'b1;
    end
    return r;
  endfunction

  // R4 cost written from rise/fall classification
  function automatic int bCost(input logic [PAY-1:0] y, input logic [PAY-1:0] x);
    int c;
    logic r0, f0, r1, f1;
    c = 0;
    for (int i = 0; i < PAY - 1; i++) begin
      r0 = !y[i] && x[i];   f0 = y[i] && !x[i];
      r1 = !y[i+1] && x[i+1]; f1 = y[i+1] && !x[i+1];
      if ((r0 || f0) != (r1 || f1)) c = c + 1;
      else if ((r0 && f1) || (f0 && r1)) c = c + 2;
    end
    return c;
  endfunction

  // strict unique cheapest candidate, else none (R5-R8 in cost form)
  function automatic logic [1:0] bPick(input logic [PAY-1:0] y, input logic [PAY-1:0] x);
    int c [4];
    bit strict;
    for (int m = 0; m < 4; m++) c[m] = bCost(y, x ^ bMask(2'(m)));
    for (int m = 1; m < 4; m++) begin
      strict = 1'b1;
      for (int k = 0; k < 4; k++)
        if (k != m && c[k] <= c[m]) strict = 1'b0;
      if (strict) return 2'(m);
    end
    return 2'b00;
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendFlit(input logic [PAY-1:0] p, input string req);
    logic [1:0] m;
    logic [W-1:0] nl;
    int cSent, cRaw;
    m  = bPick(expLink[PAY-1:0], p);
    nl = {m != 2'b00, p ^ bMask(m)};
    @(negedge clk);
    flitValid = 1'b1;
    payload   = p;
    @(negedge clk);
    flitValid = 1'b0;
    checkEq({req, " mode"}, 32'(mode), 32'(m));
    checkEq({req, " linkWord"}, 32'(linkWord), 32'(nl));
    checkEq("R3 flag", 32'(linkWord[W-1]), 32'(mode != 2'b00));
    checkEq("R3 unmask", 32'(linkWord[PAY-1:0] ^ bMask(mode)), 32'(p));
    cSent = bCost(expLink[PAY-1:0], linkWord[PAY-1:0]);
    cRaw  = bCost(expLink[PAY-1:0], p);
    checkEq("R9 not worse", 32'(cSent <= cRaw), 32'd1);
    if (mode != 2'b00) checkEq("R9 strict", 32'(cSent < cRaw), 32'd1);
    seenMode[mode]++;
    expLink = nl;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R1 linkWord", 32'(linkWord), 32'd0);
    checkEq("R1 mode", 32'(mode), 32'd0);
    rstN = 1'b1;
    expLink = '0;
  endtask

  task automatic testTie();
    // from zero, 0x5555: odd and even tie at cost 0 -> no inversion
    sendFlit(15'h5555, "R8 tie");
    checkEq("R8 tie literal mode", 32'(mode), 32'd0);
    checkEq("R8 tie literal word", 32'(linkWord), 32'h5555);
  endtask

  task automatic testFull();
    // every pair switches in opposite directions -> full inversion
    sendFlit(15'h2AAA, "R5 full");
    checkEq("R5 literal mode", 32'(mode), 32'd3);
    checkEq("R5 literal word", 32'(linkWord), 32'hD555);
  endtask

  task automatic testIdle();
    logic [W-1:0] keepW;
    logic [1:0] keepM;
    keepW = linkWord;
    keepM = mode;
    @(negedge clk);
    payload = 15'h1234;
    repeat (3) @(negedge clk);
    payload = 15'h7ACE;
    @(negedge clk);
    checkEq("R2 idle word", 32'(linkWord), 32'(keepW));
    checkEq("R2 idle mode", 32'(mode), 32'(keepM));
  endtask

  task automatic testUniform();
    sendFlit(15'h7FFF, "R4 all rise");
    sendFlit(15'h0000, "R4 all fall");
    sendFlit(15'h00FF, "R10 half");
    sendFlit(15'h00FF, "R10 repeat");
  endtask

  task automatic testRandom(input int n);
    for (int k = 0; k < n; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      sendFlit(lfsr[PAY-1:0], "R6 R7 R10 random");
    end
  endtask

  task automatic testMidReset();
    sendFlit(15'h3C3C, "R2 before reset");
    testReset();
  endtask

  initial begin
    for (int m = 0; m < 4; m++) seenMode[m] = 0;
    testReset();
    testTie();
    testFull();
    testIdle();
    testUniform();
    testRandom(600);
    testMidReset();
    testRandom(200);
    checkEq("R6 odd chosen", 32'(seenMode[2] > 0), 32'd1);
    checkEq("R7 even chosen", 32'(seenMode[1] > 0), 32'd1);
    checkEq("R5 full chosen", 32'(seenMode[3] > 0), 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule